// File: doc/BRIEF.md
# Addressable LED Bit Encoder

This block turns a stream of 24-bit pixel colours into the packed word stream that a downstream serializer shifts out on a one-wire addressable LED chain. Each colour bit becomes three wire slots. A 1 becomes the slots high, high, low. A 0 becomes high, low, low. Slots are packed most significant bit first into 32-bit words. A pixel therefore fills 72 slots, or two and a quarter words, and pixels run on across word boundaries without gaps.

A frame begins with a handshake on the frame port, which carries the number of pixels. The pixels then arrive on a ready/valid input, with the red byte in bits 23:16, green in 15:8 and blue in 7:0. The block sends the green byte first, then red, then blue, each byte starting at its most significant bit. Words leave on a ready/valid output.

After the last pixel, a partly filled word is padded with zeros and sent. One all-zero word follows it so that the line falls idle. The number of words in a frame never exceeds a fixed buffer maximum. Pixels that would not fit are still consumed but produce no words.

Top module: `led_bit_encoder`

## Requirements
- R1: The wire order of a pixel is green byte, red byte, blue byte, each from its bit 7 down to bit 0. The input layout is red at bits 23:16, green at 15:8 and blue at 7:0.
- R2: A colour bit of 1 yields the three slots 1, 1, 0 in wire order.
- R3: A colour bit of 0 yields the three slots 1, 0, 0 in wire order.
- R4: Slots fill each output word from bit 31 down to bit 0. A frame of N pixels carries 72·N contiguous slots over ceil(72·N/32) data words, with no gap between pixels.
- R5: The last data word of a frame has zeros in every bit below the last slot.
- R6: Exactly one all-zero word follows the data words of a frame, unless the cap in R7 is reached first.
- R7: A frame emits min(ceil(9·N/4)+1, MAX_WORDS) words. Every one of its N pixels is still accepted, including those whose slots are dropped. The number of words emitted for a frame never exceeds MAX_WORDS.
- R8: While word_ready_i is low, word_o and word_valid_o hold. The pixel input stalls rather than losing or repeating a slot.
- R9: While rst_ni is low, word_valid_o and pix_ready_o are low and frame_ready_o is high. A reset in the middle of a frame discards the partial word and the slot position, so the next frame starts clean.
- R10: pix_ready_o is high only inside a frame. A frame with N = 0 emits a single all-zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | Frame start request |
| frame_ready_o | output | 1 | Idle; a frame start is accepted |
| frame_count_i | input | CNT_W | Pixel count of the frame |
| pix_valid_i | input | 1 | Pixel valid |
| pix_ready_o | output | 1 | Pixel accepted this cycle |
| pix_data_i | input | 24 | Pixel colour {red, green, blue} |
| word_valid_o | output | 1 | Output word valid |
| word_ready_i | input | 1 | Downstream takes the word |
| word_o | output | 32 | Packed slot word, first slot in bit 31 |

## Verification
The hardest case to reach is the word cap. In a long frame it cuts off both the trailing zero word and later pixel data, while the block must still drain every remaining pixel. The bench reaches it by building the device with a small cap and sending frames of seven and nine pixels, so that ceil(9·N/4)+1 just exceeds or clearly exceeds the cap. Separate vectors add output backpressure and input gaps, so that completed words sit in the output register while slots wait in the pixel buffer. A directed reset in the middle of a frame checks that no stale partial word leaks into the next frame.

// File: rtl/led_enc_pkg.sv
package led_enc_pkg;
  localparam int unsigned COLOR_W      = 24;
  localparam int unsigned SLOT_PER_BIT = 3;
  localparam int unsigned PIX_SLOTS    = COLOR_W * SLOT_PER_BIT;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned SREM_W       = $clog2(PIX_SLOTS + 1);
  localparam int unsigned FILL_W       = $clog2(WORD_W + 1);

  localparam logic [SLOT_PER_BIT-1:0] PAT_ONE  = 3'b110;
  localparam logic [SLOT_PER_BIT-1:0] PAT_ZERO = 3'b100;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TRAIL} frame_st_e;

  typedef struct packed {
    logic [7:0] red;
    logic [7:0] grn;
    logic [7:0] blu;
  } rgb_t;
endpackage

// File: rtl/led_slot_expand.sv
module led_slot_expand
  import led_enc_pkg::*;
(
  input  rgb_t                 pix_i,
  output logic [PIX_SLOTS-1:0] slots_o
);
  logic [COLOR_W-1:0] wire_order;

  assign wire_order = {pix_i.grn, pix_i.red, pix_i.blu};

  for (genvar w = 0; w < COLOR_W; w++) begin : g_bit
    assign slots_o[PIX_SLOTS-1-SLOT_PER_BIT*w -: SLOT_PER_BIT] =
      wire_order[COLOR_W-1-w] ? PAT_ONE : PAT_ZERO;
  end
endmodule

// File: rtl/led_word_packer.sv
module led_word_packer
  import led_enc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [PIX_SLOTS-1:0] slots_i,
  input  logic                 flush_i,
  input  logic                 trail_i,
  input  logic                 drop_i,
  output logic                 push_o,
  output logic                 srem_zero_o,
  output logic                 fill_zero_o,
  output logic [WORD_W-1:0]    word_o,
  output logic                 word_valid_o,
  input  logic                 word_ready_i
);
  logic [PIX_SLOTS-1:0] sbuf_q;
  logic [SREM_W-1:0]    srem_q;
  logic [WORD_W-1:0]    acc_q;
  logic [FILL_W-1:0]    fill_q;
  logic                 full, move, out_free;
  logic [FILL_W-1:0]    room;
  logic [SREM_W-1:0]    take;

  assign full     = fill_q == FILL_W'(WORD_W);
  assign room     = FILL_W'(WORD_W) - fill_q;
  assign take     = (srem_q < SREM_W'(room)) ? srem_q : SREM_W'(room);
  assign move     = (srem_q != '0) && !full;
  assign out_free = !word_valid_o || word_ready_i;
  // a full, flushed or trailer word leaves only when the output slot is free
  assign push_o   = out_free && (full || (flush_i && fill_q != '0) || trail_i);

  assign srem_zero_o = srem_q == '0;
  assign fill_zero_o = fill_q == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sbuf_q       <= '0;
      srem_q       <= '0;
      acc_q        <= '0;
      fill_q       <= '0;
      word_o       <= '0;
      word_valid_o <= 1'b0;
    end else begin
      if (load_i) begin
        sbuf_q <= slots_i;
        srem_q <= SREM_W'(PIX_SLOTS);
      end else if (move) begin
        sbuf_q <= sbuf_q << take;
        srem_q <= srem_q - take;
      end
      if (push_o) begin
        acc_q  <= '0;
        fill_q <= '0;
      end else if (move) begin
        // bits past srem are zero, so over-reading the top pads for free
        acc_q  <= acc_q | (sbuf_q[PIX_SLOTS-1 -: WORD_W] >> fill_q);
        fill_q <= fill_q + FILL_W'(take);
      end
      if (push_o && !drop_i) begin
        word_o       <= acc_q;
        word_valid_o <= 1'b1;
      end else if (word_ready_i) begin
        word_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/led_frame_ctrl.sv
module led_frame_ctrl
  import led_enc_pkg::*;
#(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned MAX_WORDS = 1024,
  parameter int unsigned WCNT_W    = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_valid_i,
  input  logic [CNT_W-1:0] frame_count_i,
  output logic             frame_ready_o,
  input  logic             pix_valid_i,
  output logic             pix_ready_o,
  input  logic             srem_zero_i,
  input  logic             fill_zero_i,
  input  logic             push_i,
  output logic             load_o,
  output logic             flush_o,
  output logic             trail_o,
  output logic             drop_o
);
  frame_st_e         state_q;
  logic [CNT_W-1:0]  left_q;
  logic [WCNT_W-1:0] wcnt_q;

  assign frame_ready_o = state_q == ST_IDLE;
  assign drop_o        = wcnt_q >= WCNT_W'(MAX_WORDS);
  assign pix_ready_o   = (state_q == ST_RUN) && (left_q != '0) && srem_zero_i;
  assign load_o        = pix_valid_i && pix_ready_o;
  assign flush_o       = (state_q == ST_RUN) && (left_q == '0) && srem_zero_i;
  assign trail_o       = (state_q == ST_TRAIL) && !drop_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      wcnt_q  <= '0;
    end else begin
      if (push_i && !drop_o) wcnt_q <= wcnt_q + 1'b1;
      unique case (state_q)
        ST_IDLE: if (frame_valid_i) begin
          left_q  <= frame_count_i;
          wcnt_q  <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (load_o) left_q <= left_q - 1'b1;
          if (left_q == '0 && srem_zero_i && fill_zero_i) state_q <= ST_TRAIL;
        end
        ST_TRAIL: if (drop_o || push_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/led_bit_encoder.sv
module led_bit_encoder
  import led_enc_pkg::*;
#(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned MAX_WORDS = 1024
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_valid_i,
  output logic               frame_ready_o,
  input  logic [CNT_W-1:0]   frame_count_i,
  input  logic               pix_valid_i,
  output logic               pix_ready_o,
  input  logic [COLOR_W-1:0] pix_data_i,
  output logic               word_valid_o,
  input  logic               word_ready_i,
  output logic [WORD_W-1:0]  word_o
);
  localparam int unsigned WCNT_W = $clog2(MAX_WORDS + 1);

  rgb_t                 pix;
  logic [PIX_SLOTS-1:0] slots;
  logic load, flush, trail, drop, push, srem_zero, fill_zero;

  assign pix = rgb_t'(pix_data_i);

  led_slot_expand u_expand (
    .pix_i   (pix),
    .slots_o (slots)
  );

  led_frame_ctrl #(
    .CNT_W     (CNT_W),
    .MAX_WORDS (MAX_WORDS),
    .WCNT_W    (WCNT_W)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_valid_i (frame_valid_i),
    .frame_count_i (frame_count_i),
    .frame_ready_o (frame_ready_o),
    .pix_valid_i   (pix_valid_i),
    .pix_ready_o   (pix_ready_o),
    .srem_zero_i   (srem_zero),
    .fill_zero_i   (fill_zero),
    .push_i        (push),
    .load_o        (load),
    .flush_o       (flush),
    .trail_o       (trail),
    .drop_o        (drop)
  );

  led_word_packer u_packer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .slots_i      (slots),
    .flush_i      (flush),
    .trail_i      (trail),
    .drop_i       (drop),
    .push_o       (push),
    .srem_zero_o  (srem_zero),
    .fill_zero_o  (fill_zero),
    .word_o       (word_o),
    .word_valid_o (word_valid_o),
    .word_ready_i (word_ready_i)
  );
endmodule

// File: rtl/led_bit_encoder_chk.sv
module led_bit_encoder_chk #(
  parameter int unsigned MAX_WORDS = 1024
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        frame_valid_i,
  input logic        frame_ready_o,
  input logic        pix_ready_o,
  input logic        word_valid_o,
  input logic        word_ready_i,
  input logic [31:0] word_o,
  input logic        drop_i
);
  int unsigned sent_q;
  logic        prev_v_q, prev_r_q, new_word;

  // count words entering the output register, so a pending word of the previous frame is not charged
  assign new_word = word_valid_o && (!prev_v_q || prev_r_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sent_q   <= 0;
      prev_v_q <= 1'b0;
      prev_r_q <= 1'b0;
    end else begin
      prev_v_q <= word_valid_o;
      prev_r_q <= word_ready_i;
      if (frame_valid_i && frame_ready_o) sent_q <= 0;
      else if (new_word) sent_q <= sent_q + 1;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_state_R9: assert (!word_valid_o && frame_ready_o && !pix_ready_o);
    end
  end

  assert_hold_word_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && !word_ready_i |=> word_valid_o && $stable(word_o));

  assert_pix_in_frame_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_ready_o |-> !frame_ready_o);

  assert_trailer_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_ready_o) && !$past(drop_i) |-> word_valid_o && word_o == 32'h0);

  assert_word_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sent_q <= MAX_WORDS);
endmodule

bind led_bit_encoder led_bit_encoder_chk #(.MAX_WORDS(MAX_WORDS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_valid_i (frame_valid_i),
  .frame_ready_o (frame_ready_o),
  .pix_ready_o   (pix_ready_o),
  .word_valid_o  (word_valid_o),
  .word_ready_i  (word_ready_i),
  .word_o        (word_o),
  .drop_i        (drop)
);

// File: tb/led_bit_encoder_bench.sv
`timescale 1ns/1ps
module led_bit_encoder_bench;
  localparam int CNT_W = 10;
  localparam int MAXW  = 16;
  localparam int NVEC  = 12;
  // {count[31:24], seed[23:16], ready_mode[15:12], stall_mode[11:8], exp_words[7:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h01_11_0_0_04, 32'h02_22_0_0_06, 32'h03_33_0_0_08, 32'h04_44_0_0_0A,
    32'h05_55_0_0_0D, 32'h06_66_0_0_0F, 32'h07_77_0_0_10, 32'h09_99_0_0_10,
    32'h00_10_0_0_01, 32'h04_FF_2_0_0A, 32'h05_00_3_2_0D, 32'h06_5A_1_3_0F
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_valid_i = 1'b0;
  logic frame_ready_o;
  logic [CNT_W-1:0] frame_count_i = '0;
  logic pix_valid_i = 1'b0;
  logic pix_ready_o;
  logic [23:0] pix_data_i = '0;
  logic word_valid_o;
  logic word_ready_i = 1'b1;
  logic [31:0] word_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] got [64];

  always #2.5 clk = ~clk;

  led_bit_encoder #(.CNT_W(CNT_W), .MAX_WORDS(MAXW)) u_led_bit_encoder (
    .clk_i(clk), .rst_ni(rst_ni),
    .frame_valid_i(frame_valid_i), .frame_ready_o(frame_ready_o), .frame_count_i(frame_count_i),
    .pix_valid_i(pix_valid_i), .pix_ready_o(pix_ready_o), .pix_data_i(pix_data_i),
    .word_valid_o(word_valid_o), .word_ready_i(word_ready_i), .word_o(word_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] pix_of(input int seed, input int i);
    if (seed == 0) return 24'h000000;
    if (seed == 1) return 24'h008001;
    if (seed == 255) return 24'hFFFFFF;
    return 24'((seed * 7919) ^ (i * 104729) ^ (i << 13) ^ (seed << 9));
  endfunction

  // wire order G,R,B; 1 -> 110, 0 -> 100; first slot in bit 31
  function automatic logic [31:0] model_word(input int seed, input int n, input int j);
    logic [31:0] w = '0;
    int dw = (9 * n + 3) / 4;
    if (j >= dw) return 32'h0;
    for (int b = 0; b < 32; b++) begin
      int s = 32 * j + b;
      int p = s / 72;
      int r = s % 72;
      logic [23:0] px;
      logic [23:0] grb;
      if (p < n) begin
        px  = pix_of(seed, p);
        grb = {px[15:8], px[23:16], px[7:0]};
        w[31-b] = ((r % 3) == 0) ? 1'b1 : ((r % 3) == 1) ? grb[23 - r / 3] : 1'b0;
      end
    end
    return w;
  endfunction

  task automatic run_frame(input int n, input int seed, input int rm, input int sm,
                           output int nw, output int npix);
    int  cyc = 0;
    bit  acc = 0;
    bit  done = 0;
    nw = 0;
    npix = 0;
    @(negedge clk);
    frame_count_i = CNT_W'(n);
    frame_valid_i = 1'b1;
    while (!done && cyc < 5000) begin
      if (cyc != 0) @(negedge clk);
      cyc++;
      if (acc) frame_valid_i = 1'b0;
      word_ready_i = (rm == 0) || (cyc % (rm + 1) != 0);
      pix_valid_i  = acc && (npix < n) && ((sm == 0) || (cyc % (sm + 1) != 0));
      pix_data_i   = pix_of(seed, npix);
      #1;
      if (pix_valid_i && pix_ready_o) npix++;
      if (word_valid_o && word_ready_i) begin
        if (nw < 64) got[nw] = word_o;
        nw++;
      end
      done = acc && !frame_valid_i && frame_ready_o && !word_valid_o;
      if (frame_valid_i && frame_ready_o) acc = 1;
    end
    pix_valid_i  = 1'b0;
    word_ready_i = 1'b1;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int nw, np, n, seed, rm, sm, ex;
    repeat (3) @(negedge clk);
    #1;
    check(!word_valid_o && frame_ready_o && !pix_ready_o, "R9 reset state",
          {29'h0, word_valid_o, frame_ready_o, pix_ready_o}, 32'h2);
    @(negedge clk);
    rst_ni = 1'b1;

    // table walk: R4 contents, R5 padding, R6 trailer, R7 count and cap, R8 stalls, R10 empty frame
    for (int v = 0; v < NVEC; v++) begin
      n    = int'(VEC[v][31:24]);
      seed = int'(VEC[v][23:16]);
      rm   = int'(VEC[v][15:12]);
      sm   = int'(VEC[v][11:8]);
      ex   = int'(VEC[v][7:0]);
      run_frame(n, seed, rm, sm, nw, np);
      check(nw == ex, "R7 word count", 32'(nw), 32'(ex));
      check(np == n, "R7 pixels consumed", 32'(np), 32'(n));
      for (int j = 0; j < nw && j < 64; j++)
        check(got[j] == model_word(seed, n, j), "R4 word content", got[j], model_word(seed, n, j));
      if (n == 0) check(got[0] == 32'h0, "R10 empty frame word", got[0], 32'h0);
    end

    // directed: pixel {r=00,g=80,b=01}; R1 order, R2/R3 patterns, R5 pad, R6 trailer
    run_frame(1, 1, 0, 0, nw, np);
    check(nw == 4, "R6 word count", 32'(nw), 32'd4);
    check(got[0] == 32'hD2492492, "R1 R2 R3 first word", got[0], 32'hD2492492);
    check(got[2] == 32'h26000000, "R5 padded last word", got[2], 32'h26000000);
    check(got[3] == 32'h0, "R6 trailer", got[3], 32'h0);

    // all-ones pixel under heavy backpressure: R2, R8
    run_frame(1, 255, 3, 0, nw, np);
    check(got[0] == 32'hDB6DB6DB, "R2 R8 ones word", got[0], 32'hDB6DB6DB);

    // reset mid-frame: R9
    @(negedge clk);
    frame_count_i = CNT_W'(5);
    frame_valid_i = 1'b1;
    word_ready_i  = 1'b0;
    @(negedge clk);
    frame_valid_i = 1'b0;
    pix_valid_i   = 1'b1;
    pix_data_i    = 24'hFFFFFF;
    repeat (4) @(negedge clk);
    rst_ni = 1'b0;
    pix_valid_i = 1'b0;
    #1;
    check(!word_valid_o && frame_ready_o && !pix_ready_o, "R9 mid-frame reset",
          {29'h0, word_valid_o, frame_ready_o, pix_ready_o}, 32'h2);
    @(negedge clk);
    rst_ni = 1'b1;
    word_ready_i = 1'b1;
    run_frame(1, 1, 0, 0, nw, np);
    check(nw == 4, "R9 clean frame count", 32'(nw), 32'd4);
    check(got[0] == 32'hD2492492, "R9 clean first word", got[0], 32'hD2492492);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule